// File: doc/BRIEF.md
# Rotating Register File Renamer

This block holds the register file of a software-pipelined loop engine and translates the architectural register specifiers of two read ports and one write port into physical register numbers. The specifier space has two parts. The lower part is static, and those specifiers address their own physical registers directly. The upper part is rotating. A rotating specifier is offset by a base value, modulo the size of the rotating part, so that each loop iteration works in a shifted window of physical registers.

A loop-branch strobe steps the base down by one. A value written under rotating specifier k is therefore found under specifier k+d after d further iterations. A compiler can use this to express a d-iteration latency as a difference between specifier numbers. A synchronous load port sets the base to any value. The base controller picks one of three named operations each cycle:

- BASE_HOLD keeps the base.
- BASE_STEP decrements it, with wrap-around.
- BASE_SET loads it. BASE_SET takes priority over BASE_STEP.

Reset clears the base and every register. Reads are combinational. A write lands at the clock edge and uses the base in effect before any rotation at that same edge.

Top module: `rot_regfile`

## Requirements
- R1: After reset, `cur_base` is 0 and every valid specifier reads 0.
- R2: A specifier below NUM_STATIC (default 0..7) addresses the same physical register whatever the base.
- R3: A specifier s with NUM_STATIC <= s < NUM_STATIC+NUM_ROT (default 8..39) addresses physical register NUM_STATIC + ((s - NUM_STATIC + base) mod NUM_ROT), and never a static register.
- R4: With `loop_rotate` high and `base_load` low, the base becomes base-1 at the next edge, wrapping from 0 to NUM_ROT-1. With both low, the base holds.
- R5: With `base_load` high, the base becomes `base_load_val` at the next edge, whether or not `loop_rotate` is high.
- R6: A value written under rotating specifier k is read under specifier NUM_STATIC + ((k - NUM_STATIC + d) mod NUM_ROT) after exactly d rotations.
- R7: A write in a rotation cycle is placed using the pre-rotation base, and reads in that cycle also use the pre-rotation base.
- R8: A read of the physical register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R9: A specifier of NUM_STATIC+NUM_ROT or above (default 40..63) reads 0, and a write to it changes no register.
- R10: With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_spec | input | 6 | Read port A specifier |
| rd_a_data | output | 32 | Read port A data |
| rd_b_spec | input | 6 | Read port B specifier |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 6 | Write specifier |
| wr_data | input | 32 | Write data |
| loop_rotate | input | 1 | Loop-branch strobe; steps the base down |
| base_load | input | 1 | Load the base from base_load_val |
| base_load_val | input | 5 | Value for a base load |
| cur_base | output | 5 | Current rotating base |

## Verification
On every cycle, the assertions check three things:

- The base controller's step, load and hold transitions, including the wrap from 0.
- That static specifiers pass through the translators unchanged, that rotating ones always land inside the rotating region, and that out-of-range specifiers are flagged invalid.
- That an accepted write is found at its physical slot one cycle later.

Only the bench's scenarios can show the behaviour as seen through the ports: data written under one specifier reappears under a shifted specifier after several rotations; writes and reads in a rotation cycle use the old base; a read of a register being written returns the old value; and out-of-range writes leave all registers untouched. A behavioural model compares both read ports and the base every cycle, under both directed and random traffic.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_SET  = 2'd2
    } base_op_e;
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
    import rrf_pkg::*;
#(
    parameter int NUM_ROT = 32,
    localparam int ROT_W  = (NUM_ROT > 1) ? $clog2(NUM_ROT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic             load_req,
    input  logic [ROT_W-1:0] load_val,
    output logic [ROT_W-1:0] base
);
    localparam logic [ROT_W-1:0] TOP_VAL = ROT_W'(NUM_ROT - 1);
    localparam logic [ROT_W-1:0] ONE     = ROT_W'(1);

    base_op_e         op;
    logic [ROT_W-1:0] base_nxt;

    always_comb begin
        if (load_req)      op = BASE_SET;
        else if (step_req) op = BASE_STEP;
        else               op = BASE_HOLD;
    end

    always_comb begin
        unique case (op)
            BASE_STEP: base_nxt = (base == '0) ? TOP_VAL : base - ONE;
            BASE_SET:  base_nxt = load_val;
            default:   base_nxt = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base <= '0;
        else        base <= base_nxt;
    end

    AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !load_req) |=> base == (($past(base) == '0) ? TOP_VAL : $past(base) - ONE)); // R4
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_req && !load_req) |=> $stable(base)); // R4
    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> base == $past(load_val)); // R5
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate #(
    parameter int NUM_STATIC = 8,
    parameter int NUM_ROT    = 32,
    localparam int TOTAL     = NUM_STATIC + NUM_ROT,
    localparam int SPEC_W    = $clog2(TOTAL),
    localparam int ROT_W     = (NUM_ROT > 1) ? $clog2(NUM_ROT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPEC_W-1:0] spec,
    input  logic [ROT_W-1:0]  base,
    output logic [SPEC_W-1:0] phys,
    output logic              valid
);
    localparam logic [SPEC_W:0] NS_X  = (SPEC_W+1)'(NUM_STATIC);
    localparam logic [SPEC_W:0] TOT_X = (SPEC_W+1)'(TOTAL);
    localparam logic [ROT_W:0]  NR_X  = (ROT_W+1)'(NUM_ROT);

    logic [SPEC_W:0] spec_x;
    logic [SPEC_W:0] rel;
    logic [ROT_W:0]  sum;
    logic [ROT_W:0]  wrapped;
    logic            is_static;

    always_comb begin
        spec_x    = {1'b0, spec};
        is_static = spec_x < NS_X;
        valid     = spec_x < TOT_X;
        rel       = spec_x - NS_X;
        sum       = {1'b0, rel[ROT_W-1:0]} + {1'b0, base};
        wrapped   = (sum >= NR_X) ? sum - NR_X : sum;
        if (is_static) phys = spec;
        else           phys = SPEC_W'(NUM_STATIC) + SPEC_W'(wrapped);
    end

    AST_STATIC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, spec} < NS_X) |-> phys == spec); // R2
    AST_ROT_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_static) |-> ({1'b0, phys} >= NS_X && {1'b0, phys} < TOT_X)); // R3
    AST_BAD_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, spec} >= TOT_X) |-> !valid); // R9
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int TOTAL  = 40,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic              ra_ok,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              rb_ok,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic              w_ok,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data
);
    logic [DATA_W-1:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
        end else if (we && w_ok) begin
            mem[w_idx] <= w_data;
        end
    end

    assign ra_data = ra_ok ? mem[ra_idx] : '0;
    assign rb_data = rb_ok ? mem[rb_idx] : '0;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_ok) |=> mem[$past(w_idx)] == $past(w_data)); // R8
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int NUM_STATIC = 8,
    parameter int NUM_ROT    = 32,
    parameter int DATA_W     = 32,
    localparam int TOTAL     = NUM_STATIC + NUM_ROT,
    localparam int SPEC_W    = $clog2(TOTAL),
    localparam int ROT_W     = (NUM_ROT > 1) ? $clog2(NUM_ROT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPEC_W-1:0] rd_a_spec,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SPEC_W-1:0] rd_b_spec,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              loop_rotate,
    input  logic              base_load,
    input  logic [ROT_W-1:0]  base_load_val,
    output logic [ROT_W-1:0]  cur_base
);
    localparam int NPORT = 3;

    logic [ROT_W-1:0]  base;
    logic [SPEC_W-1:0] spec_v [NPORT];
    logic [SPEC_W-1:0] phys_v [NPORT];
    logic              ok_v   [NPORT];

    assign spec_v[0] = rd_a_spec;
    assign spec_v[1] = rd_b_spec;
    assign spec_v[2] = wr_spec;

    rrf_base_ctrl #(.NUM_ROT(NUM_ROT)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_req (loop_rotate),
        .load_req (base_load),
        .load_val (base_load_val),
        .base     (base)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_xlate
        rrf_xlate #(.NUM_STATIC(NUM_STATIC), .NUM_ROT(NUM_ROT)) u_xl (
            .clk   (clk),
            .rst_n (rst_n),
            .spec  (spec_v[p]),
            .base  (base),
            .phys  (phys_v[p]),
            .valid (ok_v[p])
        );
    end

    rrf_storage #(.TOTAL(TOTAL), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (phys_v[0]),
        .ra_ok   (ok_v[0]),
        .ra_data (rd_a_data),
        .rb_idx  (phys_v[1]),
        .rb_ok   (ok_v[1]),
        .rb_data (rd_b_data),
        .we      (wr_en),
        .w_ok    (ok_v[2]),
        .w_idx   (phys_v[2]),
        .w_data  (wr_data)
    );

    assign cur_base = base;

    AST_RESET_BASE: assert property (@(posedge clk)
        $past(!rst_n) |-> cur_base == '0); // R1
endmodule

// File: tb/rot_regfile_test.sv
module rot_regfile_test;
    localparam int NS = 8;
    localparam int NR = 32;
    localparam int TOT = NS + NR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_a_spec = '0, rd_b_spec = '0, wr_spec = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0, loop_rotate = 1'b0, base_load = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  base_load_val = '0;
    logic [4:0]  cur_base;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_base = 0;
    int unsigned m_reg [TOT];

    always #5 clk = ~clk;

    rot_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_spec(rd_a_spec), .rd_a_data(rd_a_data),
        .rd_b_spec(rd_b_spec), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .loop_rotate(loop_rotate), .base_load(base_load),
        .base_load_val(base_load_val), .cur_base(cur_base)
    );

    function automatic int map(int s, int b);
        if (s < NS) return s;
        if (s < TOT) return NS + ((s - NS + b) % NR);
        return -1;
    endfunction

    function automatic int unsigned model_rd(int s);
        int p = map(s, m_base);
        return (p < 0) ? 0 : m_reg[p];
    endfunction

    task automatic check(string tag, int unsigned got, int unsigned exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // one cycle: drive, compare against the model, clock, update the model
    task automatic step(int ra, int rb, bit we, int ws, int unsigned wd,
                        bit rot, bit ld, int lv, string tag);
        int wp;
        @(negedge clk);
        rd_a_spec = 6'(ra); rd_b_spec = 6'(rb);
        wr_en = we; wr_spec = 6'(ws); wr_data = wd;
        loop_rotate = rot; base_load = ld; base_load_val = 5'(lv);
        #1;
        check({tag, " rd_a"}, rd_a_data, model_rd(ra));
        check({tag, " rd_b"}, rd_b_data, model_rd(rb));
        check({tag, " base"}, 32'(cur_base), 32'(m_base));
        @(posedge clk);
        wp = map(ws, m_base);
        if (we && wp >= 0) m_reg[wp] = wd;
        if (ld) m_base = lv;
        else if (rot) m_base = (m_base + NR - 1) % NR;
    endtask

    task automatic idle(int ra, int rb, string tag);
        step(ra, rb, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < TOT; i++) m_reg[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 base after reset", 32'(cur_base), 0);
        for (int s = 0; s < TOT; s += 2) idle(s, s + 1, "R1");

        // R10: fill all registers, then idle with wr_en low
        for (int s = 0; s < TOT; s++) step(s, 0, 1, s, 32'h1000 + s, 0, 0, 0, "R10 fill");
        step(5, 20, 0, 5, 32'hDEAD, 0, 0, 0, "R10");
        idle(5, 20, "R10 no write");
        check("R10 spec5 unchanged", rd_a_data, 32'h1005);

        // R4: wrap from 0 to 31
        step(0, 0, 0, 0, 0, 1, 0, 0, "R4");
        #1 check("R4 wrap", 32'(cur_base), 31);

        // R5: load wins over rotate
        step(0, 0, 0, 0, 0, 1, 1, 17, "R5");
        #1 check("R5 load priority", 32'(cur_base), 17);

        // R2: static specifiers ignore base 17
        idle(2, 7, "R2");
        check("R2 static 2", rd_a_data, 32'h1002);
        check("R2 static 7", rd_b_data, 32'h1007);

        // R3: spec 8 with base 17 -> phys 25 (written as spec 25 at base 0)
        idle(8, 39, "R3");
        check("R3 spec8 base17", rd_a_data, 32'h1019);
        check("R3 spec39 base17 wraps", rd_b_data, 32'h1000 + 8 + ((31 + 17) % 32));

        // R6: write spec 10, rotate 3 times, read spec 13
        step(0, 0, 1, 10, 32'hA6A6, 0, 1, 0, "R6 load0");
        step(0, 0, 1, 10, 32'hA6A6, 0, 0, 0, "R6 write");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R6 rot");
        idle(13, 10, "R6");
        check("R6 spec13 after 3 rotations", rd_a_data, 32'hA6A6);
        // wrap of the specifier: write spec 38, rotate 4, read spec 8+((30+4)%32)=10
        step(0, 0, 1, 38, 32'hB7B7, 0, 0, 0, "R6 write wrap");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R6 rot");
        idle(10, 0, "R6 wrap");
        check("R6 spec10 after wrap", rd_a_data, 32'hB7B7);

        // R7: rotate and write in the same cycle use the old base
        step(0, 0, 0, 0, 0, 0, 1, 5, "R7 load");
        step(8, 0, 1, 8, 32'hC7C7, 1, 0, 0, "R7 rot+write");
        idle(9, 0, "R7");
        check("R7 spec9 after rot+write", rd_a_data, 32'hC7C7);

        // R8: read the register being written in the same cycle
        step(3, 3, 1, 3, 32'hD8D8, 0, 0, 0, "R8 same cycle");
        check("R8 old value same cycle", rd_a_data, 32'h1003);
        idle(3, 0, "R8 next");
        check("R8 new value next cycle", rd_a_data, 32'hD8D8);

        // R9: out-of-range specifiers
        step(45, 63, 1, 50, 32'hE9E9, 0, 0, 0, "R9");
        check("R9 spec45 reads zero", rd_a_data, 0);
        for (int s = 0; s < TOT; s += 2) idle(s, s + 1, "R9 no change");

        // random traffic, compared with the model each cycle
        for (int i = 0; i < 3000; i++)
            step($urandom_range(63), $urandom_range(63), 1'($urandom_range(1)),
                 $urandom_range(63), $urandom, 1'($urandom_range(3) == 0),
                 1'($urandom_range(15) == 0), $urandom_range(31), "R3 R4 R5 random");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule